// File: doc/BRIEF.md
# Frame Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit processor core and takes over whenever a periodic frame interrupt has to be entered or left. It latches frame ticks, keeps the interrupt-disable flag and an in-handler marker, and decides at each instruction boundary whether the pending tick is taken. When it is taken, the sequencer saves the return address and the flags byte on a stack that grows downward. It then reads a 16-bit handler address from a fixed vector location. Finally it gives the core a new program counter, a cleared flags byte with only the disable bit set, and the new stack pointer.

A return request reverses the save. The flags byte and the return address come back off the stack, and the restored flags decide whether interrupts are enabled again. A halt request parks the core until a tick can be taken. If interrupts are disabled, the halt never ends. The memory side is a request/acknowledge stream of one byte at a time. The sequencer raises `mem_valid` and holds address, direction and write data steady until the memory answers with `mem_ready`. Read data is sampled in the cycle where both are high, so the memory may stall for any number of cycles. While `stall` is high the core must not advance. A core instruction boundary (`boundary`) is only acted on while `stall` is low.

Top module: `frm_irq_seq_top`

## Requirements
- R1: While reset is held, and right after it is released, `if_flag` is 1 (interrupts disabled), `in_handler`, `stall`, `halted`, `mem_valid` and `upd_valid` are 0.
- R2: A `frame_tick` is remembered until it is taken. It is taken only at a cycle with `boundary` high (or while halted) and with `if_flag` low. A boundary while `if_flag` is 1 leaves the tick pending and starts nothing.
- R3: Entry writes three bytes, with the stack pointer taken from `core_sp` at the take. The first is PC[15:8] at sp-1, the second is PC[7:0] at sp-2, and the third is the flags byte at sp-3. The flags byte has bit 4, the disable bit, forced to 0.
- R4: After the saves, entry reads the vector low byte at 0xFF00 and then the high byte at 0xFF01. It presents `upd_pc` = {high, low}.
- R5: An entry ends with a single-cycle `upd_valid` that carries `upd_flags` = 0x10 and `upd_sp` = sp-3. `stall` stays high from the cycle after the take through that cycle. From the take onward, `if_flag` and `in_handler` are 1.
- R6: A return request reads the flags byte at sp, PC[7:0] at sp+1 and PC[15:8] at sp+2. It presents those as `upd_flags`/`upd_pc` with `upd_sp` = sp+3. After the `upd_valid` cycle, `if_flag` equals bit 4 of the restored byte and `in_handler` is 0.
- R7: A set-disable request makes `if_flag` 1. A clear-disable request makes it 0 outside a handler and has no effect while `in_handler` is 1.
- R8: A halt request raises `halted` and `stall` until a tick can be taken. The entry then saves the `core_pc` presented by the core.
- R9: A halt request made while `if_flag` is 1 keeps `halted` high with no memory traffic, whatever ticks arrive.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged in the next cycle.
- R11: When a tick is taken at a boundary, any request presented at that boundary (halt, return, set or clear) is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame timer pulse |
| boundary | input | 1 | Core is between instructions; requests below are valid |
| halt_req | input | 1 | Halt instruction at this boundary |
| cif_req | input | 1 | Clear-disable (enable interrupts) instruction |
| sif_req | input | 1 | Set-disable instruction |
| iret_req | input | 1 | Return-from-interrupt instruction |
| core_pc | input | 16 | Address to resume at |
| core_flags | input | 8 | Core flags byte |
| core_sp | input | 16 | Core stack pointer |
| mem_valid | output | 1 | Byte access request |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_valid && mem_ready` |
| upd_valid | output | 1 | One-cycle strobe: core loads PC, flags, SP |
| upd_pc | output | 16 | New program counter |
| upd_flags | output | 8 | New flags byte |
| upd_sp | output | 16 | New stack pointer |
| if_flag | output | 1 | Interrupt-disable flag |
| in_handler | output | 1 | A handler is running |
| halted | output | 1 | Core is parked by a halt |
| stall | output | 1 | Core must hold; sequencer busy |

## Verification
A take at a boundary clock edge shows `mem_valid` in the next cycle. Each byte then costs one cycle plus the cycles `mem_ready` is held low. `upd_valid` rises one cycle after the last handshake, and flag changes from a take, a set/clear request or the update cycle are visible one cycle after that edge. The bench holds a behavioural model that applies the same inputs at each rising edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due, including the cycles of memory stall. Extra scenario checks read back the stack bytes and the restored values after each sequence has finished.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_HALT = 3'd1,
    SQ_SAVE = 3'd2,
    SQ_LOAD = 3'd3,
    SQ_UPD  = 3'd4
  } sq_state_e;

  function automatic logic [7:0] only_bit(input int pos);
    logic [7:0] m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/frm_irq_pending.sv
module frm_irq_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !take) || tick;
  end

  assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !take |=> pend);
endmodule

// File: rtl/frm_irq_flagctl.sv
module frm_irq_flagctl (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic req_ok,
  input  logic sif,
  input  logic cif,
  input  logic exit_done,
  input  logic pop_if,
  output logic if_flag,
  output logic in_handler
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_flag    <= 1'b1;
      in_handler <= 1'b0;
    end else if (take) begin
      if_flag    <= 1'b1;
      in_handler <= 1'b1;
    end else if (exit_done) begin
      if_flag    <= pop_if;
      in_handler <= 1'b0;
    end else if (req_ok && sif) begin
      if_flag <= 1'b1;
    end else if (req_ok && cif && !in_handler) begin
      if_flag <= 1'b0;
    end
  end

  assert_cif_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler && req_ok && cif |=> if_flag);
  assert_take_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> if_flag && in_handler);
endmodule

// File: rtl/frm_irq_seq.sv
module frm_irq_seq
  import frm_irq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int IF_BIT   = 4,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          halt_req,
  input  logic          iret_req,
  input  logic          pend,
  input  logic          if_flag,
  input  logic [AW-1:0] core_pc,
  input  logic [DW-1:0] core_flags,
  input  logic [AW-1:0] core_sp,
  output logic          take,
  output logic          req_ok,
  output logic          exit_done,
  output logic          pop_if,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          upd_valid,
  output logic [AW-1:0] upd_pc,
  output logic [DW-1:0] upd_flags,
  output logic [AW-1:0] upd_sp,
  output logic          halted,
  output logic          stall
);
  localparam int NB        = AW / DW;
  localparam int SAVE_LAST = 2 * NB;
  localparam int LOAD_LAST = NB;
  localparam int SW        = $clog2(SAVE_LAST + 1);
  localparam logic [DW-1:0] IF_MASK = DW'(1) << IF_BIT;

  sq_state_e     st;
  logic [SW-1:0] step;
  logic [AW-1:0] base;
  logic [AW-1:0] pc_cap;
  logic [DW-1:0] fl_cap;
  logic [AW-1:0] acc;
  logic [DW-1:0] pop_fl;
  logic          upd_exit;
  logic          hs;
  logic [AW-1:0] step_w;
  logic [AW-1:0] acc_next;

  assign take   = pend && !if_flag && ((st == SQ_IDLE && boundary) || st == SQ_HALT);
  assign req_ok = (st == SQ_IDLE) && boundary && !take;

  assign mem_valid = (st == SQ_SAVE) || (st == SQ_LOAD);
  assign mem_we    = (st == SQ_SAVE) && (int'(step) <= NB);
  assign hs        = mem_valid && mem_ready;
  assign step_w    = AW'(step);
  assign acc_next  = {mem_rdata, acc[AW-1:DW]};

  always_comb begin
    mem_addr = '0;
    if (st == SQ_SAVE) begin
      if (int'(step) <= NB) mem_addr = base - step_w - AW'(1);
      else                  mem_addr = VEC_ADDR + step_w - AW'(NB + 1);
    end else if (st == SQ_LOAD) begin
      mem_addr = base + step_w;
    end
  end

  always_comb begin
    mem_wdata = fl_cap;
    for (int i = 0; i < NB; i++) begin
      if (int'(step) == i) mem_wdata = pc_cap[(NB-1-i)*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      step      <= '0;
      base      <= '0;
      pc_cap    <= '0;
      fl_cap    <= '0;
      acc       <= '0;
      pop_fl    <= '0;
      upd_exit  <= 1'b0;
      upd_valid <= 1'b0;
      upd_pc    <= '0;
      upd_flags <= '0;
      upd_sp    <= '0;
    end else begin
      case (st)
        SQ_IDLE, SQ_HALT: begin
          if (take) begin
            st     <= SQ_SAVE;
            step   <= '0;
            base   <= core_sp;
            pc_cap <= core_pc;
            fl_cap <= core_flags & ~IF_MASK;
          end else if (req_ok && iret_req) begin
            st   <= SQ_LOAD;
            step <= '0;
            base <= core_sp;
          end else if (req_ok && halt_req) begin
            st <= SQ_HALT;
          end
        end
        SQ_SAVE: begin
          if (hs) begin
            if (int'(step) > NB) acc <= acc_next;
            if (int'(step) == SAVE_LAST) begin
              st        <= SQ_UPD;
              upd_valid <= 1'b1;
              upd_pc    <= acc_next;
              upd_flags <= IF_MASK;
              upd_sp    <= base - AW'(NB + 1);
              upd_exit  <= 1'b0;
            end else begin
              step <= step + SW'(1);
            end
          end
        end
        SQ_LOAD: begin
          if (hs) begin
            if (step == '0) pop_fl <= mem_rdata;
            else            acc    <= acc_next;
            if (int'(step) == LOAD_LAST) begin
              st        <= SQ_UPD;
              upd_valid <= 1'b1;
              upd_pc    <= acc_next;
              upd_flags <= pop_fl;
              upd_sp    <= base + AW'(NB + 1);
              upd_exit  <= 1'b1;
            end else begin
              step <= step + SW'(1);
            end
          end
        end
        default: begin
          st        <= SQ_IDLE;
          upd_valid <= 1'b0;
        end
      endcase
    end
  end

  assign exit_done = (st == SQ_UPD) && upd_exit;
  assign pop_if    = upd_flags[IF_BIT];
  assign halted    = (st == SQ_HALT);
  assign stall     = (st != SQ_IDLE);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  assert_upd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid && !stall);
  assert_halt_stuck_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted && if_flag |=> halted && !mem_valid);
  assert_first_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> mem_valid && mem_we && mem_addr == $past(core_sp) - AW'(1));
endmodule

// File: rtl/frm_irq_seq_top.sv
module frm_irq_seq_top #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int IF_BIT   = 4,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFF00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          boundary,
  input  logic          halt_req,
  input  logic          cif_req,
  input  logic          sif_req,
  input  logic          iret_req,
  input  logic [AW-1:0] core_pc,
  input  logic [DW-1:0] core_flags,
  input  logic [AW-1:0] core_sp,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          upd_valid,
  output logic [AW-1:0] upd_pc,
  output logic [DW-1:0] upd_flags,
  output logic [AW-1:0] upd_sp,
  output logic          if_flag,
  output logic          in_handler,
  output logic          halted,
  output logic          stall
);
  logic pend;
  logic take;
  logic req_ok;
  logic exit_done;
  logic pop_if;

  frm_irq_pending u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (frame_tick),
    .take  (take),
    .pend  (pend)
  );

  frm_irq_flagctl u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .req_ok     (req_ok),
    .sif        (sif_req),
    .cif        (cif_req),
    .exit_done  (exit_done),
    .pop_if     (pop_if),
    .if_flag    (if_flag),
    .in_handler (in_handler)
  );

  frm_irq_seq #(
    .AW       (AW),
    .DW       (DW),
    .IF_BIT   (IF_BIT),
    .VEC_ADDR (VEC_ADDR)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .halt_req   (halt_req),
    .iret_req   (iret_req),
    .pend       (pend),
    .if_flag    (if_flag),
    .core_pc    (core_pc),
    .core_flags (core_flags),
    .core_sp    (core_sp),
    .take       (take),
    .req_ok     (req_ok),
    .exit_done  (exit_done),
    .pop_if     (pop_if),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_flags  (upd_flags),
    .upd_sp     (upd_sp),
    .halted     (halted),
    .stall      (stall)
  );
endmodule

// File: tb/frm_irq_seq_top_bench.sv
`timescale 1ns/1ps
module frm_irq_seq_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0, boundary = 1'b0;
  logic        halt_req = 1'b0, cif_req = 1'b0, sif_req = 1'b0, iret_req = 1'b0;
  logic [15:0] core_pc = 16'h0, core_sp = 16'h0;
  logic [7:0]  core_flags = 8'h0;
  logic        mem_valid, mem_we, upd_valid, if_flag, in_handler, halted, stall;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr, upd_pc, upd_sp;
  logic [7:0]  mem_wdata, upd_flags;
  logic [7:0]  mem_rdata = 8'h0;

  frm_irq_seq_top u_frm_irq_seq_top (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .boundary(boundary),
    .halt_req(halt_req), .cif_req(cif_req), .sif_req(sif_req), .iret_req(iret_req),
    .core_pc(core_pc), .core_flags(core_flags), .core_sp(core_sp),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_flags(upd_flags), .upd_sp(upd_sp),
    .if_flag(if_flag), .in_handler(in_handler), .halted(halted), .stall(stall));

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Byte memory
  logic [7:0] mem_arr [int];
  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem_arr.exists(int'(a))) return mem_arr[int'(a)];
    return a[7:0] ^ 8'h5A;
  endfunction

  // Reference model state (behavioural)
  int m_mode = 0;   // 0 idle, 1 halt, 2 save, 3 load, 4 update
  int m_step = 0, m_base = 0, m_pc = 0, m_fl = 0, m_lo = 0, m_pfl = 0;
  int m_upc = 0, m_ufl = 0, m_usp = 0;
  bit m_if = 1, m_inh = 0, m_pend = 0, m_exit = 0;

  always @(posedge clk) begin
    bit tk, ok;
    int old_mode;
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_if = 1; m_inh = 0; m_pend = 0; m_exit = 0;
    end else begin
      old_mode = m_mode;
      tk = m_pend && !m_if && ((m_mode == 0 && boundary) || m_mode == 1);
      ok = (m_mode == 0) && boundary && !tk;
      if (tk) begin m_if = 1; m_inh = 1; end
      else if (old_mode == 4 && m_exit) begin m_if = m_ufl[4]; m_inh = 0; end
      else if (ok && sif_req) m_if = 1;
      else if (ok && cif_req && !m_inh) m_if = 0;
      m_pend = (m_pend && !tk) || frame_tick;
      case (old_mode)
        0, 1: begin
          if (tk) begin
            m_mode = 2; m_step = 0; m_base = core_sp; m_pc = core_pc; m_fl = core_flags & 8'hEF;
          end else if (ok && iret_req) begin
            m_mode = 3; m_step = 0; m_base = core_sp;
          end else if (ok && halt_req) m_mode = 1;
        end
        2: if (mem_ready) begin
          if (m_step == 3) m_lo = mem_rdata;
          if (m_step == 4) begin
            m_mode = 4; m_exit = 0; m_upc = {mem_rdata, 8'(m_lo)}; m_ufl = 8'h10;
            m_usp = (m_base - 3) & 16'hFFFF;
          end else m_step++;
        end
        3: if (mem_ready) begin
          if (m_step == 0) m_pfl = mem_rdata;
          if (m_step == 1) m_lo = mem_rdata;
          if (m_step == 2) begin
            m_mode = 4; m_exit = 1; m_upc = {mem_rdata, 8'(m_lo)}; m_ufl = m_pfl;
            m_usp = (m_base + 3) & 16'hFFFF;
          end else m_step++;
        end
        default: m_mode = 0;
      endcase
    end
  end

  function automatic int e_addr();
    if (m_mode == 2) return (m_step <= 2) ? ((m_base - m_step - 1) & 16'hFFFF) : (16'hFF00 + m_step - 3);
    return (m_base + m_step) & 16'hFFFF;
  endfunction
  function automatic int e_wdata();
    if (m_step == 0) return (m_pc >> 8) & 8'hFF;
    if (m_step == 1) return m_pc & 8'hFF;
    return m_fl;
  endfunction

  // Memory responder, per-cycle comparison, R10 watch
  bit         cmp_on = 0, fast = 0;
  logic [7:0] lfsr = 8'hA5;
  bit         cap_v = 0, cap_r = 0, cap_w = 0;
  logic [15:0] cap_a = 0;
  logic [7:0]  cap_d = 0;

  always @(negedge clk) begin
    bit ev;
    if (cap_v && cap_r && cap_w) mem_arr[int'(cap_a)] = cap_d;
    if (cmp_on && !done) begin
      if (cap_v && !cap_r)
        chk(mem_valid && mem_addr == cap_a && mem_wdata == cap_d, "R10 held request", int'(mem_addr), int'(cap_a));
      chk(stall == (m_mode != 0), "R5 stall", stall, m_mode != 0);
      chk(halted == (m_mode == 1), "R8 halted", halted, m_mode == 1);
      chk(if_flag == m_if, "R7 if_flag", if_flag, m_if);
      chk(in_handler == m_inh, "R6 in_handler", in_handler, m_inh);
      ev = (m_mode == 2 || m_mode == 3);
      chk(mem_valid == ev, "R3 mem_valid", mem_valid, ev);
      if (ev && mem_valid) begin
        chk(mem_we == (m_mode == 2 && m_step <= 2), "R3 mem_we", mem_we, m_mode == 2 && m_step <= 2);
        chk(int'(mem_addr) == e_addr(), "R4 mem_addr", int'(mem_addr), e_addr());
        if (mem_we) chk(int'(mem_wdata) == e_wdata(), "R3 mem_wdata", int'(mem_wdata), e_wdata());
      end
      chk(upd_valid == (m_mode == 4), "R5 upd_valid", upd_valid, m_mode == 4);
      if (upd_valid && m_mode == 4) begin
        chk(int'(upd_pc) == m_upc, "R6 upd_pc", int'(upd_pc), m_upc);
        chk(int'(upd_flags) == m_ufl, "R6 upd_flags", int'(upd_flags), m_ufl);
        chk(int'(upd_sp) == m_usp, "R5 upd_sp", int'(upd_sp), m_usp);
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready = fast ? 1'b1 : (lfsr[0] | lfsr[1]);
    mem_rdata = rd(mem_addr);
    cap_v = mem_valid; cap_r = mem_ready; cap_w = mem_we; cap_a = mem_addr; cap_d = mem_wdata;
  end

  // Stimulus helpers (each starts and ends right after a falling edge)
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic tick();
    frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
  endtask
  task automatic bnd(input bit h, input bit c, input bit s, input bit r);
    boundary = 1'b1; halt_req = h; cif_req = c; sif_req = s; iret_req = r;
    @(negedge clk);
    boundary = 1'b0; halt_req = 0; cif_req = 0; sif_req = 0; iret_req = 0;
  endtask
  logic [15:0] g_pc, g_sp;
  logic [7:0]  g_fl;
  task automatic wait_upd(input string tag);
    bit seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (upd_valid) begin seen = 1; g_pc = upd_pc; g_fl = upd_flags; g_sp = upd_sp; end
    end
    chk(seen, tag, seen, 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    mem_arr[16'hFF00] = 8'h34;
    mem_arr[16'hFF01] = 8'h12;
    cyc(4);
    // R1 during reset
    chk(if_flag == 1 && stall == 0 && mem_valid == 0 && upd_valid == 0, "R1 in reset", {if_flag, stall}, 2);
    rst_n = 1'b1; cmp_on = 1;
    cyc(1);
    chk(if_flag == 1, "R1 if_flag", if_flag, 1);
    chk(in_handler == 0 && halted == 0 && stall == 0, "R1 idle", {in_handler, halted, stall}, 0);

    // R2: tick held while disabled
    core_pc = 16'h0456; core_flags = 8'hA3; core_sp = 16'h0000;
    tick();
    bnd(0, 0, 0, 0); cyc(2);
    chk(stall == 0 && mem_valid == 0, "R2 no take while disabled", stall, 0);
    bnd(0, 1, 0, 0);
    chk(if_flag == 0, "R7 cif outside handler", if_flag, 0);
    cyc(1);
    chk(stall == 0, "R2 pending waits for boundary", stall, 0);
    bnd(0, 0, 0, 0);
    wait_upd("R5 entry update seen");
    chk(g_pc == 16'h1234, "R4 vector pc", g_pc, 16'h1234);
    chk(g_fl == 8'h10, "R5 entry flags", g_fl, 8'h10);
    chk(g_sp == 16'hFFFD, "R5 entry sp", g_sp, 16'hFFFD);
    chk(rd(16'hFFFF) == 8'h04, "R3 pc high byte", rd(16'hFFFF), 8'h04);
    chk(rd(16'hFFFE) == 8'h56, "R3 pc low byte", rd(16'hFFFE), 8'h56);
    chk(rd(16'hFFFD) == 8'hA3, "R3 flags byte", rd(16'hFFFD), 8'hA3);
    cyc(1);
    chk(if_flag == 1 && in_handler == 1, "R5 handler flags", {if_flag, in_handler}, 3);

    // R7: CIF ignored in handler
    bnd(0, 1, 0, 0); cyc(1);
    chk(if_flag == 1, "R7 cif ignored in handler", if_flag, 1);

    // R6: return
    core_sp = 16'hFFFD;
    bnd(0, 0, 0, 1);
    wait_upd("R6 return update seen");
    chk(g_pc == 16'h0456, "R6 restored pc", g_pc, 16'h0456);
    chk(g_fl == 8'hA3, "R6 restored flags", g_fl, 8'hA3);
    chk(g_sp == 16'h0000, "R6 restored sp", g_sp, 16'h0000);
    cyc(1);
    chk(if_flag == 0 && in_handler == 0, "R6 flags after return", {if_flag, in_handler}, 0);

    // R11: take beats a halt at the same boundary
    tick();
    core_pc = 16'h0777; core_sp = 16'h8000; core_flags = 8'h01;
    bnd(1, 0, 0, 0);
    wait_upd("R11 entry instead of halt");
    cyc(1);
    chk(halted == 0 && stall == 0, "R11 halt dropped", halted, 0);
    chk(rd(16'h7FFF) == 8'h07 && rd(16'h7FFE) == 8'h77, "R11 saved pc", rd(16'h7FFE), 8'h77);
    core_sp = 16'h7FFD;
    bnd(0, 0, 0, 1);
    wait_upd("R6 second return");
    cyc(1);

    // R8: halt waits for a tick
    fast = 1;
    core_pc = 16'h0ABC; core_sp = 16'h4000;
    bnd(1, 0, 0, 0); cyc(20);
    chk(halted == 1 && stall == 1, "R8 halted waiting", {halted, stall}, 3);
    tick();
    wait_upd("R8 wake update");
    chk(g_pc == 16'h1234, "R8 vector after wake", g_pc, 16'h1234);
    chk(rd(16'h3FFF) == 8'h0A && rd(16'h3FFE) == 8'hBC, "R8 saved halt pc", rd(16'h3FFE), 8'hBC);
    cyc(1);
    core_sp = 16'h3FFD;
    bnd(0, 0, 0, 1);
    wait_upd("R6 third return");
    cyc(1);
    fast = 0;

    // R7 set, then R9 halt forever
    bnd(0, 0, 1, 0);
    chk(if_flag == 1, "R7 sif sets", if_flag, 1);
    bnd(1, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin tick(); cyc(20); end
    chk(halted == 1 && mem_valid == 0, "R9 halt with disabled stays", {halted, mem_valid}, 2);
    finish_run();
  end
endmodule